// File: doc/BRIEF.md
# Channel Rate Divider

This block turns a fast reference clock into a train of single-cycle clock-enable strobes at a lower, programmable rate. It serves one output channel of a frequency synthesizer: downstream logic runs on the reference clock and qualifies its work with the strobe. The divide ratio is the product of an 8-bit programmable field and a fixed post-divide factor set by a parameter.

The channel has two gating controls: a disable bit from the channel's own control word and a hold bit from a control word it shares with its neighbours. It runs only when both are clear. A third input reports whether the upstream synthesizer is running; while it is low the channel emits nothing, even if enabled. A programmed field of zero selects the slowest rate rather than a bypass. A new field value takes effect only at the end of the current period, so a period is never cut short. Whenever the channel stops, its count starts again from zero.

Top module: `chan_rate_div`

## Requirements
- R1: `chanActive` is 1 exactly when `chanDisable` is 0 and `holdBit` is 0, with no delay, and it does not depend on `parentRun`.
- R2: While `chanActive` is 0, `clkEn` is 0 from the next clock edge on.
- R3: While `parentRun` is 0, `clkEn` is 0 from the next clock edge on, even if `chanActive` is 1.
- R4: A `divField` value of 0 gives a field ratio of 255, so the period is 255 × FIXED_DIV reference cycles.
- R5: With the channel running steadily, `clkEn` rises once every `divField` × FIXED_DIV reference cycles (field values 1 to 255).
- R6: A new `divField` value is taken only at the terminal count. The period in progress keeps its old length. A value present in the terminal cycle itself sets the length of the following period.
- R7: The internal count clears whenever the channel is not running. After `chanActive` and `parentRun` both become 1 before edge 1, the first strobe is visible after edge N, where N is the full ratio.
- R8: `clkEn` comes from a register and, when the ratio is above 1, stays high for exactly one reference cycle.
- R9: During and right after reset, `clkEn` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| parentRun | input | 1 | Upstream synthesizer running (locked) |
| chanDisable | input | 1 | Channel disable bit from the channel control word |
| holdBit | input | 1 | Channel hold bit from the shared control word |
| divField | input | DIV_WIDTH | Programmable divide field, 0 selects the maximum |
| clkEn | output | 1 | One-cycle enable strobe at the divided rate |
| chanActive | output | 1 | Channel enabled status |

## Verification
The terminal count can land in the same cycle as a change of the divide field or a change of the gating bits. The bench provokes both by measuring a period and then changing the input exactly one cycle before the expected strobe. In the first case it changes `divField`: the strobe must still arrive on time, and the period after it must use the new ratio. In the second case it sets `chanDisable`: the strobe must be suppressed, and no strobe may appear later.

// File: rtl/chan_rate_div_pkg.sv
package chan_rate_div_pkg;

  // Strobes passed from the control unit to the counting datapath.
  typedef struct packed {
    logic advance; // channel running: count this cycle
    logic clear;   // channel stopped: zero the count, reload the ratio
  } ctrlStrobe_t;

endpackage

// File: rtl/chan_rate_ctrl.sv
module chan_rate_ctrl
  import chan_rate_div_pkg::*;
#(
  parameter int DIV_WIDTH = 8,
  parameter int FIXED_DIV = 1,
  parameter int RATIO_W   = 10
) (
  input  logic                 parentRun,
  input  logic                 chanDisable,
  input  logic                 holdBit,
  input  logic [DIV_WIDTH-1:0] divField,
  output ctrlStrobe_t          strobe,
  output logic [RATIO_W-1:0]   newRatio,
  output logic                 chanActive
);

  localparam logic [DIV_WIDTH-1:0] FIELD_MAX = {DIV_WIDTH{1'b1}};

  logic [DIV_WIDTH-1:0] fieldEff;
  logic                 running;

  // Both gating bits must be clear for the channel to be enabled.
  assign chanActive = ~chanDisable & ~holdBit;
  assign running    = chanActive & parentRun;

  assign strobe.advance = running;
  assign strobe.clear   = ~running;

  // Zero selects the largest field value, not a bypass.
  assign fieldEff = (divField == '0) ? FIELD_MAX : divField;

  generate
    if (FIXED_DIV == 1) begin : g_noPost
      assign newRatio = RATIO_W'(fieldEff);
    end else begin : g_post
      localparam logic [RATIO_W-1:0] POST = RATIO_W'(FIXED_DIV);
      assign newRatio = RATIO_W'(fieldEff) * POST;
    end
  endgenerate

endmodule

// File: rtl/chan_rate_dp.sv
module chan_rate_dp
  import chan_rate_div_pkg::*;
#(
  parameter int RATIO_W = 10
) (
  input  logic               clk,
  input  logic               rst_n,
  input  ctrlStrobe_t        strobe,
  input  logic [RATIO_W-1:0] newRatio,
  output logic               clkEn
);

  logic [RATIO_W-1:0] count;
  logic [RATIO_W-1:0] ratioQ;
  logic               termCount;

  assign termCount = (count == ratioQ - RATIO_W'(1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      count  <= '0;
      ratioQ <= RATIO_W'(1);
      clkEn  <= 1'b0;
    end else if (strobe.clear) begin
      count  <= '0;
      ratioQ <= newRatio;
      clkEn  <= 1'b0;
    end else if (strobe.advance) begin
      if (termCount) begin
        count  <= '0;
        ratioQ <= newRatio; // ratio changes only at the period boundary
        clkEn  <= 1'b1;
      end else begin
        count  <= count + RATIO_W'(1);
        clkEn  <= 1'b0;
      end
    end else begin
      clkEn <= 1'b0;
    end
  end

endmodule

// File: rtl/chan_rate_div.sv
module chan_rate_div
  import chan_rate_div_pkg::*;
#(
  parameter int DIV_WIDTH = 8,
  parameter int FIXED_DIV = 1
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 parentRun,
  input  logic                 chanDisable,
  input  logic                 holdBit,
  input  logic [DIV_WIDTH-1:0] divField,
  output logic                 clkEn,
  output logic                 chanActive
);

  localparam int RATIO_W = DIV_WIDTH + $clog2(FIXED_DIV + 1) + 1;

  ctrlStrobe_t        strobe;
  logic [RATIO_W-1:0] newRatio;

  chan_rate_ctrl #(
    .DIV_WIDTH(DIV_WIDTH),
    .FIXED_DIV(FIXED_DIV),
    .RATIO_W  (RATIO_W)
  ) u_ctrl (
    .parentRun  (parentRun),
    .chanDisable(chanDisable),
    .holdBit    (holdBit),
    .divField   (divField),
    .strobe     (strobe),
    .newRatio   (newRatio),
    .chanActive (chanActive)
  );

  chan_rate_dp #(
    .RATIO_W(RATIO_W)
  ) u_dp (
    .clk     (clk),
    .rst_n   (rst_n),
    .strobe  (strobe),
    .newRatio(newRatio),
    .clkEn   (clkEn)
  );

endmodule

// File: rtl/chan_rate_div_chk.sv
module chan_rate_div_chk #(
  parameter int DIV_WIDTH = 8,
  parameter int FIXED_DIV = 1
) (
  input logic clk,
  input logic rst_n,
  input logic parentRun,
  input logic chanDisable,
  input logic holdBit,
  input logic clkEn,
  input logic chanActive
);

  localparam int MAX_RATIO = ((1 << DIV_WIDTH) - 1) * FIXED_DIV;
  localparam int GAP_W     = $clog2(MAX_RATIO + 2) + 1;

  logic [GAP_W-1:0] gapCnt;

  // Cycles since the last strobe while running without interruption.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) gapCnt <= '0;
    else if (clkEn || !(chanActive && parentRun)) gapCnt <= '0;
    else gapCnt <= gapCnt + GAP_W'(1);
  end

  // R2
  inactive_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !chanActive |=> !clkEn);

  // R3
  parent_stop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !parentRun |=> !clkEn);

  // R4
  max_gap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    gapCnt <= GAP_W'(MAX_RATIO));

  // R9
  reset_quiet_chk: assert property (@(posedge clk)
    !rst_n |=> !clkEn);

  generate
    if (FIXED_DIV > 1) begin : g_wide
      // R8
      one_cycle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        clkEn |=> !clkEn);

      // R7
      fresh_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(chanActive) |=> !clkEn);
    end
  endgenerate

endmodule

bind chan_rate_div chan_rate_div_chk #(
  .DIV_WIDTH(DIV_WIDTH),
  .FIXED_DIV(FIXED_DIV)
) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .parentRun  (parentRun),
  .chanDisable(chanDisable),
  .holdBit    (holdBit),
  .clkEn      (clkEn),
  .chanActive (chanActive)
);

// File: tb/chan_rate_div_tb.sv
module chan_rate_div_tb;

  localparam int FIX = 3;
  localparam int NV  = 5;
  localparam logic [7:0] DIVS [NV] = '{8'd1, 8'd2, 8'd5, 8'd17, 8'd0};

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       parentRun = 1'b0;
  logic       chanDisable = 1'b1;
  logic       holdBit = 1'b0;
  logic [7:0] divField = 8'd1;
  logic       clkEn;
  logic       chanActive;

  int checks = 0;
  int failures = 0;
  bit done = 1'b0;

  always #2 clk = ~clk; // 250 MHz

  chan_rate_div #(.DIV_WIDTH(8), .FIXED_DIV(FIX)) u_dut (
    .clk(clk), .rst_n(rst_n), .parentRun(parentRun),
    .chanDisable(chanDisable), .holdBit(holdBit), .divField(divField),
    .clkEn(clkEn), .chanActive(chanActive)
  );

  function automatic int ratioOf(input logic [7:0] d);
    return ((d == 8'd0) ? 255 : int'(d)) * FIX;
  endfunction

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // Counts negedges until a strobe is seen; returns 0 if none within lim.
  task automatic waitPulse(input int lim, output int k);
    k = 0;
    for (int i = 1; i <= lim; i++) begin
      @(negedge clk);
      if (clkEn) begin k = i; return; end
    end
  endtask

  task automatic countPulses(input int n, output int p);
    p = 0;
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      if (clkEn) p++;
    end
  endtask

  initial begin
    int k;
    int p;
    repeat (3) @(negedge clk);
    check("R9 reset clkEn", int'(clkEn), 0);
    rst_n = 1'b1;
    @(negedge clk);
    check("R9 after reset clkEn", int'(clkEn), 0);
    check("R1 disabled status", int'(chanActive), 0);
    parentRun = 1'b1;

    // Vector table: first delay, steady period, strobe width.
    for (int v = 0; v < NV; v++) begin
      chanDisable = 1'b1;
      divField = DIVS[v];
      repeat (2) @(negedge clk);
      chanDisable = 1'b0;
      waitPulse(2000, k);
      check("R7 first strobe delay", k, ratioOf(DIVS[v]));
      waitPulse(2000, k);
      check((DIVS[v] == 0) ? "R4 zero field period" : "R5 period", k, ratioOf(DIVS[v]));
      @(negedge clk);
      check("R8 strobe width", int'(clkEn), 0);
    end

    // R1/R2: hold bit gates the channel.
    divField = 8'd1;
    holdBit = 1'b1;
    #0;
    check("R1 hold status", int'(chanActive), 0);
    countPulses(20, p);
    check("R2 no strobes while held", p, 0);
    holdBit = 1'b0;
    #0;
    check("R1 enabled status", int'(chanActive), 1);

    // R3: parent stopped.
    parentRun = 1'b0;
    countPulses(20, p);
    check("R3 no strobes without parent", p, 0);
    check("R1 status ignores parent", int'(chanActive), 1);
    parentRun = 1'b1;
    waitPulse(100, k);
    check("R7 restart after parent", k, 3);

    // R7: stop mid-period, count restarts from zero.
    divField = 8'd4;
    waitPulse(100, k);
    waitPulse(100, k);
    repeat (5) @(negedge clk);
    chanDisable = 1'b1;
    @(negedge clk);
    chanDisable = 1'b0;
    waitPulse(100, k);
    check("R7 full period after re-enable", k, 12);

    // R6: change mid-period keeps the current period.
    divField = 8'd2;
    waitPulse(100, k);
    waitPulse(100, k);
    repeat (2) @(negedge clk);
    divField = 8'd5;
    waitPulse(100, k);
    check("R6 old period kept", k, 4);
    waitPulse(100, k);
    check("R6 new period used", k, 15);

    // R6: change arriving in the terminal cycle.
    divField = 8'd2;
    waitPulse(100, k);
    repeat (5) @(negedge clk);
    divField = 8'd1;
    waitPulse(100, k);
    check("R6 strobe on time at terminal change", k, 1);
    waitPulse(100, k);
    check("R6 period after terminal change", k, 3);

    // R2: disable arriving in the terminal cycle.
    divField = 8'd2;
    waitPulse(100, k);
    waitPulse(100, k);
    repeat (5) @(negedge clk);
    chanDisable = 1'b1;
    countPulses(20, p);
    check("R2 terminal strobe suppressed", p, 0);

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      failures++;
      checks++;
      $display("FAIL watchdog actual=1 expected=0");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

endmodule